// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a CPU-side configuration window and a PCI host's configuration engine. It takes the 16-bit byte offset of a CPU access inside the window and combines it with the 16 upper address bits held in a programmable map register. The result is a 32-bit local configuration address. The device-select field of that address is one-hot, and the block turns it into a device number. It then builds a standard type-0 configuration address, with the enable bit set and the bus, device, function and register fields in place.

Every request is judged once and answered one clock later. The answer says whether the translation is usable. When it is not, three separate flags give the reason: type-1 mode selected, no device-select bit set, or bad size or alignment. For a rejected read, the block supplies the all-ones data of the access width, so the requester can return it without touching the bus. A rejected write gets no write strobe and is dropped. Each accepted access also gives a one-cycle pulse, which the host uses to clear its received-master-abort and received-target-abort status bits. The bus transaction itself happens outside this block.

Top module: `pcicfg_xlate`

## Requirements
- R1: While `rst` is high, and on the first response slot after it, every output is zero, even if `req_valid` is high during reset.
- R2: A request sampled with `req_valid` high at a rising edge gives `rsp_valid` high for exactly the following cycle. With no request, `rsp_valid` and all other outputs are zero.
- R3: The local address is `{map_hi, req_offset}`. On an accepted request, `pci_addr` is: bit 31 = 1, bits 30:24 = 0, bits 23:16 = `bus_num`, bits 15:11 = device number, bits 10:8 = local bits 10:8, bits 7:2 = local bits 7:2, bits 1:0 = 0.
- R4: The device number is the index of the lowest set bit in local address bits 31:11, counted from bit 11 as index 0. Any higher set bits are ignored.
- R5: When `map_type1` is high, the request is rejected. `type1_rej` is 1, `xlate_ok` is 0 and `pci_addr` is 0.
- R6: When `map_type1` is low and local bits 31:11 are all zero, the request is rejected with `idsel_err` = 1.
- R7: `req_size` is coded 0 = byte, 1 = half-word, 2 = word, 3 = reserved. A half-word with offset bit 0 set, a word with offset bits 1:0 non-zero, or any reserved-size request is rejected with `align_err` = 1. The alignment check does not depend on the other two checks.
- R8: For a rejected read, `dflt_rdata` is 0x000000FF for a byte, 0x0000FFFF for a half-word and 0xFFFFFFFF for a word or reserved size. For an accepted request or any write, it is 0.
- R9: `wr_strobe` is 1 only in the response to an accepted write. A rejected write leaves it at 0.
- R10: `abort_clr` pulses for one cycle in the response to each accepted read or write. A rejected request never produces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 reserved) |
| req_offset | input | 16 | Byte offset inside the configuration window |
| map_hi | input | 16 | Upper 16 local address bits from the map register |
| map_type1 | input | 1 | Map register type-1 select; 1 = reject |
| bus_num | input | 8 | Bus number placed in the PCI address |
| rsp_valid | output | 1 | Response slot for the previous cycle's request |
| xlate_ok | output | 1 | Translation accepted |
| pci_addr | output | 32 | Type-0 configuration address, 0 when rejected |
| type1_rej | output | 1 | Rejected because type-1 was selected |
| idsel_err | output | 1 | Rejected because no device-select bit was set |
| align_err | output | 1 | Rejected for misalignment or reserved size |
| dflt_rdata | output | 32 | All-ones default data for a rejected read |
| wr_strobe | output | 1 | Forward the write |
| abort_clr | output | 1 | Clear the received-abort status bits |

## Verification
All outputs come from one register stage, so any fault in the decode shows up in the very next response slot.

The bench sweeps every position of the device-select bit, including the all-zero case, with a stray higher bit added on half of the cases. Each position is combined with all function numbers, all size codes, all low offset bits, both directions and both settings of the type-1 bit.

With this sweep, the following faults each cause a mismatch in the first affected response slot:
- a wrong priority in the lowest-bit search, which gives a wrong device field;
- a dropped rejection reason, which gives a wrong flag;
- a wrong data width, which gives the wrong `dflt_rdata`;
- a strobe that escapes a rejected access.

An idle cycle after every request shows a strobe or pulse that lasts too long.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

    localparam int unsigned SEL_LSB = 11;
    localparam int unsigned DEV_W   = 5;
    localparam int unsigned FUN_W   = 3;
    localparam int unsigned REG_W   = 6;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic             ok;
        logic             t1;
        logic             nosel;
        logic             misal;
        logic             wr;
        logic [31:0]      addr;
        logic [31:0]      dflt;
    } xlate_res_t;

    function automatic logic [31:0] ones_for_size(acc_size_e sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/pcx_lsb_find.sv
module pcx_lsb_find #(
    parameter int unsigned W  = 21,
    parameter int unsigned IW = 5
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    // descending scan: the last hit written is the lowest set bit
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcx_align_chk.sv
module pcx_align_chk
    import pcx_pkg::*;
(
    input  acc_size_e  size,
    input  logic [1:0] lo,
    output logic       bad
);
    always_comb begin
        case (size)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = lo[0];
            SZ_WORD: bad = |lo;
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/pcx_pack.sv
module pcx_pack
    import pcx_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned BUS_W  = 8
) (
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FUN_W-1:0]  fun,
    input  logic [REG_W-1:0]  regno,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned LOW_W = DEV_W + FUN_W + REG_W + 2;
    localparam int unsigned PAD_W = ADDR_W - 1 - BUS_W - LOW_W;

    assign addr = {1'b1, {PAD_W{1'b0}}, bus, dev, fun, regno, 2'b00};
endmodule

// File: rtl/pcicfg_xlate.sv
module pcicfg_xlate
    import pcx_pkg::*;
#(
    parameter int unsigned OFS_W  = 16,
    parameter int unsigned MAP_W  = 16,
    parameter int unsigned BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [MAP_W-1:0]  map_hi,
    input  logic              map_type1,
    input  logic [BUS_W-1:0]  bus_num,
    output logic              rsp_valid,
    output logic              xlate_ok,
    output logic [31:0]       pci_addr,
    output logic              type1_rej,
    output logic              idsel_err,
    output logic              align_err,
    output logic [31:0]       dflt_rdata,
    output logic              wr_strobe,
    output logic              abort_clr
);
    localparam int unsigned ADDR_W = OFS_W + MAP_W;
    localparam int unsigned SEL_W  = ADDR_W - SEL_LSB;
    localparam int unsigned FUN_LO = 2 + REG_W;

    logic [ADDR_W-1:0] local_addr;
    logic [SEL_W-1:0]  sel_field;
    logic [DEV_W-1:0]  dev_num;
    logic              sel_found;
    logic              size_bad;
    logic [31:0]       packed_addr;
    acc_size_e         size_e;
    xlate_res_t        res_d;
    xlate_res_t        res_q;
    logic              vld_q;

    assign local_addr = {map_hi, req_offset};
    assign sel_field  = local_addr[ADDR_W-1:SEL_LSB];
    assign size_e     = acc_size_e'(req_size);

    pcx_lsb_find #(.W(SEL_W), .IW(DEV_W)) u_find (
        .vec   (sel_field),
        .idx   (dev_num),
        .found (sel_found)
    );

    pcx_align_chk u_align (
        .size (size_e),
        .lo   (req_offset[1:0]),
        .bad  (size_bad)
    );

    pcx_pack #(.ADDR_W(32), .BUS_W(BUS_W)) u_pack (
        .bus   (bus_num),
        .dev   (dev_num),
        .fun   (local_addr[FUN_LO+FUN_W-1:FUN_LO]),
        .regno (local_addr[FUN_LO-1:2]),
        .addr  (packed_addr)
    );

    always_comb begin
        res_d       = '0;
        res_d.t1    = map_type1;
        res_d.nosel = !map_type1 && !sel_found;
        res_d.misal = size_bad;
        res_d.ok    = !map_type1 && sel_found && !size_bad;
        res_d.wr    = req_write;
        res_d.addr  = res_d.ok ? packed_addr : '0;
        res_d.dflt  = (!res_d.ok && !req_write) ? ones_for_size(size_e) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= req_valid;
            res_q <= req_valid ? res_d : '0;
        end
    end

    assign rsp_valid  = vld_q;
    assign xlate_ok   = res_q.ok;
    assign pci_addr   = res_q.addr;
    assign type1_rej  = res_q.t1;
    assign idsel_err  = res_q.nosel;
    assign align_err  = res_q.misal;
    assign dflt_rdata = res_q.dflt;
    assign wr_strobe  = res_q.ok && res_q.wr;
    assign abort_clr  = res_q.ok;
endmodule

// File: rtl/pcicfg_xlate_chk.sv
module pcicfg_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic [15:0] req_offset,
    input logic [15:0] map_hi,
    input logic        map_type1,
    input logic        rsp_valid,
    input logic        xlate_ok,
    input logic [31:0] pci_addr,
    input logic        type1_rej,
    input logic        idsel_err,
    input logic        align_err,
    input logic [31:0] dflt_rdata,
    input logic        wr_strobe,
    input logic        abort_clr
);
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !xlate_ok && !wr_strobe && dflt_rdata == 32'h0);

    a_r3_enable_bit: assert property (@(posedge clk) disable iff (rst)
        xlate_ok |-> rsp_valid && pci_addr[31] && pci_addr[30:24] == 7'h0 && pci_addr[1:0] == 2'b00);

    a_r5_type1: assert property (@(posedge clk) disable iff (rst)
        req_valid && map_type1 |=> type1_rej && !xlate_ok && pci_addr == 32'h0);

    a_r6_nosel: assert property (@(posedge clk) disable iff (rst)
        req_valid && !map_type1 && map_hi == 16'h0 && req_offset[15:11] == 5'h0 |=> idsel_err && !xlate_ok);

    a_r7_word_align: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_size == 2'd2 && req_offset[1:0] != 2'b00 |=> align_err);

    a_r8_ok_no_dflt: assert property (@(posedge clk) disable iff (rst)
        xlate_ok |-> dflt_rdata == 32'h0);

    a_r9_write_only: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_write |=> !wr_strobe);

    a_r10_pulse_valid: assert property (@(posedge clk) disable iff (rst)
        abort_clr |-> rsp_valid && xlate_ok && !type1_rej && !idsel_err && !align_err);
endmodule

bind pcicfg_xlate pcicfg_xlate_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_offset (req_offset),
    .map_hi     (map_hi),
    .map_type1  (map_type1),
    .rsp_valid  (rsp_valid),
    .xlate_ok   (xlate_ok),
    .pci_addr   (pci_addr),
    .type1_rej  (type1_rej),
    .idsel_err  (idsel_err),
    .align_err  (align_err),
    .dflt_rdata (dflt_rdata),
    .wr_strobe  (wr_strobe),
    .abort_clr  (abort_clr)
);

// File: tb/test_pcicfg_xlate.sv
module test_pcicfg_xlate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [15:0] req_offset = 16'h0;
    logic [15:0] map_hi = 16'h0;
    logic        map_type1 = 1'b0;
    logic [7:0]  bus_num = 8'h0;
    logic        rsp_valid, xlate_ok, type1_rej, idsel_err, align_err, wr_strobe, abort_clr;
    logic [31:0] pci_addr, dflt_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pcicfg_xlate i_pcicfg_xlate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_offset(req_offset), .map_hi(map_hi),
        .map_type1(map_type1), .bus_num(bus_num), .rsp_valid(rsp_valid),
        .xlate_ok(xlate_ok), .pci_addr(pci_addr), .type1_rej(type1_rej),
        .idsel_err(idsel_err), .align_err(align_err), .dflt_rdata(dflt_rdata),
        .wr_strobe(wr_strobe), .abort_clr(abort_clr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        check({tag, " rsp_valid"}, {31'h0, rsp_valid}, 32'h0);
        check({tag, " flags"}, {26'h0, xlate_ok, type1_rej, idsel_err, align_err, wr_strobe, abort_clr}, 32'h0);
        check({tag, " addr"}, pci_addr, 32'h0);
        check({tag, " dflt"}, dflt_rdata, 32'h0);
    endtask

    // p = lowest device-select index; 21 means no bit set
    task automatic apply(input int p, input int fun, input int lo, input int sz,
                         input bit wr, input bit t1, input bit extra);
        logic [31:0] loc;
        logic [5:0]  rg;
        logic [7:0]  bus;
        bit          misal, nosel, ok;
        logic [31:0] exp_addr, exp_dflt;
        rg  = 6'((p * 7 + fun * 5) & 63);
        bus = 8'((p * 11 + fun) & 255);
        loc = 32'h0;
        if (p < 21) loc[11 + p] = 1'b1;
        if (extra && p < 20) loc[31] = 1'b1;
        loc[10:8] = 3'(fun);
        loc[7:2]  = rg;
        loc[1:0]  = 2'(lo);
        misal = (sz == 3) || (sz == 1 && loc[0]) || (sz == 2 && loc[1:0] != 2'b00);
        nosel = !t1 && (p == 21);
        ok    = !t1 && (p != 21) && !misal;
        exp_addr = ok ? {1'b1, 7'h0, bus, 5'(p), 3'(fun), rg, 2'b00} : 32'h0;
        exp_dflt = (!ok && !wr) ? ((sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF) : 32'h0;

        req_valid  = 1'b1;
        req_write  = wr;
        req_size   = 2'(sz);
        req_offset = loc[15:0];
        map_hi     = loc[31:16];
        map_type1  = t1;
        bus_num    = bus;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 rsp_valid", {31'h0, rsp_valid}, 32'h1);
        check("R3 R4 pci_addr", pci_addr, exp_addr);
        check("R5 type1_rej", {31'h0, type1_rej}, {31'h0, t1});
        check("R6 idsel_err", {31'h0, idsel_err}, {31'h0, nosel});
        check("R7 align_err", {31'h0, align_err}, {31'h0, misal});
        check("R3 xlate_ok", {31'h0, xlate_ok}, {31'h0, ok});
        check("R8 dflt_rdata", dflt_rdata, exp_dflt);
        check("R9 wr_strobe", {31'h0, wr_strobe}, {31'h0, ok && wr});
        check("R10 abort_clr", {31'h0, abort_clr}, {31'h0, ok});
        @(negedge clk);
        check_idle("R2 R10 after");
    endtask

    initial begin
        req_valid  = 1'b1;
        req_size   = 2'd2;
        req_offset = 16'h0800;
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 after reset");

        for (int t1 = 0; t1 < 2; t1++)
            for (int p = 0; p < 22; p++)
                for (int fun = 0; fun < 8; fun++)
                    for (int sz = 0; sz < 4; sz++)
                        for (int lo = 0; lo < 4; lo++)
                            for (int wr = 0; wr < 2; wr++)
                                apply(p, fun, lo, sz, wr[0], t1[0], p[0] ^ fun[0]);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule